// File: doc/BRIEF.md
# Crossbar Lane Swizzle Unit

This block redistributes one 32-bit word per lane across a set of 32 lanes. A 16-bit pattern word says, for every destination lane, which source lane it reads. Each destination lane then takes that source lane's word. If the source lane is not marked active, the destination lane takes zero instead. The pattern has two encodings. One is a quad permute, where four 2-bit selectors act within every group of four lanes. The other is a bitmask transform of the 5-bit lane id, where each bit is cleared, set, kept or inverted. Broadcast, swap and reverse over power-of-two groups are all written as bitmask patterns.

A transfer enters on a valid/ready handshake: `in_valid` with `in_ready` high. The result leaves one cycle later from a single output register on `out_valid`/`out_ready`. Back-pressure rules:
- `in_ready` is high whenever the output register is empty, or when the downstream side accepts the word it holds in that same cycle.
- While `out_valid` is high and `out_ready` is low, the output word is held unchanged and new input is refused.
- `out_valid` may rise without waiting for `out_ready`.

Top module: `lane_swizzle_xbar`

## Requirements
- R1: Pattern bit 15 = 1 selects quad mode. Destination lane `l` reads lane `4*(l/4) + s`, where `s` is pattern bits `[2k+1:2k]` and `k = l mod 4`.
- R2: Pattern bit 15 = 0 selects bitmask mode, with AND mask = bits [4:0], OR mask = bits [9:5] and XOR mask = bits [14:10]. Destination lane `l` reads lane `((l & AND) | OR) ^ XOR`. Per id bit this gives: AND=0,OR=0 clears the bit; OR=1 sets it; AND=1,OR=0 keeps it; XOR=1 inverts the result.
- R3: Broadcast over group size `n` (2, 4, 8, 16 or 32) with index `i < n` is encoded as AND = `~(n-1)`, OR = `i`, XOR = 0. Every lane of each group then reads lane `i` of its own group.
- R4: Swap of adjacent groups of size `n` (1, 2, 4, 8 or 16) is encoded as AND = 5'h1F, OR = 0, XOR = `n`. Lane `l` then reads lane `l+n` when `(l/n)` is even, and lane `l-n` otherwise.
- R5: Reverse within groups of size `n` (2, 4, 8, 16 or 32) is encoded as AND = 5'h1F, OR = 0, XOR = `n-1`. Lane `l` then reads lane `n*(l/n) + (n-1) - (l mod n)`.
- R6: A pattern of 16'h0000, the default, makes every lane read lane 0.
- R7: A destination lane whose source lane has a 0 in `in_active` outputs 32'h0. The destination lane's own active bit has no effect.
- R8: A word accepted in cycle `t` appears on `out_data` with `out_valid` high after the clock edge that ends cycle `t`. `out_valid` falls after an edge where `out_ready` is high and no new word is accepted.
- R9: `in_ready` is low while `out_valid` is high and `out_ready` is low. In that state `out_data` holds its value.
- R10: After reset, `out_valid` is 0, `out_data` is all zero and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_data | input | 1024 | Lane words, lane `l` at bits `[32l+31:32l]` |
| in_active | input | 32 | Per-lane active flag, bit `l` for lane `l` |
| pattern | input | 16 | Swizzle pattern word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 1024 | Permuted lane words, same layout as `in_data` |

## Verification
Some properties are checked by assertions on every cycle:
- the output stage's handshake timing: one-cycle latency, holding under back-pressure, and draining;
- quad mode keeping every lane inside its group of four;
- an all-clear AND/OR pattern sending every lane to the XOR lane;
- lane 0 going to zero whenever its source is inactive.

The exact lane mapping can only be shown by the bench's scenarios. They sweep every quad pattern, a wide spread of bitmask patterns, and every broadcast, swap and reverse group size, each under several active masks. A separate scenario covers the back-pressure ordering.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int PAT_W      = 16;
  localparam int MODE_BIT   = 15;
  localparam int AND_LSB    = 0;
  localparam int OR_LSB     = 5;
  localparam int XOR_LSB    = 10;
  localparam int FIELD_W    = 5;
  localparam int QSEL_W     = 2;
  localparam int QUAD_LANES = 4;

  typedef enum logic {
    SWZ_BITMASK = 1'b0,
    SWZ_QUAD    = 1'b1
  } swz_mode_e;

  function automatic swz_mode_e pat_mode(input logic [PAT_W-1:0] p);
    return p[MODE_BIT] ? SWZ_QUAD : SWZ_BITMASK;
  endfunction
endpackage

// File: rtl/swz_src_calc.sv
module swz_src_calc
  import swz_pkg::*;
#(
  parameter int LANES = 32,
  parameter int IDW   = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAT_W-1:0]       pattern,
  output logic [LANES*IDW-1:0]   src_ids
);
  swz_mode_e        mode;
  logic [IDW-1:0]   and_m, or_m, xor_m;

  always_comb begin
    mode  = pat_mode(pattern);
    and_m = pattern[AND_LSB +: IDW];
    or_m  = pattern[OR_LSB  +: IDW];
    xor_m = pattern[XOR_LSB +: IDW];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IDW-1:0] LID = IDW'(g);
    logic [QSEL_W-1:0] qsel;
    logic [IDW-1:0]    quad_src;
    logic [IDW-1:0]    mask_src;

    always_comb begin
      qsel     = pattern[QSEL_W*(g % QUAD_LANES) +: QSEL_W];
      quad_src = {LID[IDW-1:QSEL_W], qsel};
      mask_src = ((LID & and_m) | or_m) ^ xor_m;
      src_ids[g*IDW +: IDW] = (mode == SWZ_QUAD) ? quad_src : mask_src;
    end

    // R1: quad mode never leaves the group of four
    a_r1_quad_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      pattern[MODE_BIT] |-> (src_ids[g*IDW+QSEL_W +: IDW-QSEL_W] == LID[IDW-1:QSEL_W]));

    // R2: with AND and OR clear, every lane resolves to the XOR value
    a_r2_mask_const: assert property (@(posedge clk) disable iff (!rst_n)
      (!pattern[MODE_BIT] && pattern[AND_LSB +: IDW] == '0 && pattern[OR_LSB +: IDW] == '0)
        |-> (src_ids[g*IDW +: IDW] == pattern[XOR_LSB +: IDW]));
  end
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int IDW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0]  in_data,
  input  logic [LANES-1:0]     in_active,
  input  logic [LANES*IDW-1:0] src_ids,
  output logic [LANES*DW-1:0]  mux_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IDW-1:0] sel;
    always_comb begin
      sel = src_ids[g*IDW +: IDW];
      mux_data[g*DW +: DW] = in_active[sel] ? in_data[int'(sel)*DW +: DW] : '0;
    end
  end
endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_word <= in_word;
    end
  end

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_word == $past(in_word)));

  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
endmodule

// File: rtl/lane_swizzle_xbar.sv
module lane_swizzle_xbar
  import swz_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [LANES*DW-1:0]   in_data,
  input  logic [LANES-1:0]      in_active,
  input  logic [PAT_W-1:0]      pattern,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [LANES*DW-1:0]   out_data
);
  localparam int IDW = $clog2(LANES);
  localparam int WW  = LANES * DW;

  logic [LANES*IDW-1:0] src_ids;
  logic [WW-1:0]        mux_data;

  swz_src_calc #(.LANES(LANES), .IDW(IDW)) u_src (
    .clk(clk), .rst_n(rst_n), .pattern(pattern), .src_ids(src_ids)
  );

  swz_lane_mux #(.LANES(LANES), .DW(DW), .IDW(IDW)) u_mux (
    .in_data(in_data), .in_active(in_active), .src_ids(src_ids), .mux_data(mux_data)
  );

  swz_out_stage #(.W(WW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(mux_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_data)
  );

  // R7: an accepted word whose lane-0 source is inactive yields zero in lane 0
  a_r7_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_active[src_ids[IDW-1:0]]) |=> (out_data[DW-1:0] == '0));
endmodule

// File: tb/sim_lane_swizzle_xbar.sv
`timescale 1ns/1ps
module sim_lane_swizzle_xbar;
  localparam int L = 32;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [L*W-1:0] in_data = '0;
  logic [L-1:0] in_active = '0;
  logic [15:0] pattern = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [L*W-1:0] out_data;

  int checks = 0;
  int bad = 0;
  bit finished = 0;
  int exp_src [L];

  always #2 clk = ~clk;

  lane_swizzle_xbar u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_active(in_active), .pattern(pattern),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] word_of(input logic [15:0] seed, input int l);
    return {seed, 8'(l), 8'hC3};
  endfunction

  function automatic int quad_src(input logic [15:0] p, input int l);
    return (l / 4) * 4 + int'((p >> (2 * (l % 4))) & 16'h3);
  endfunction

  function automatic int mask_src(input logic [15:0] p, input int l);
    int r = 0;
    for (int b = 0; b < 5; b++) begin
      int bitv;
      if (p[5+b]) bitv = 1;
      else if (p[b]) bitv = (l >> b) & 1;
      else bitv = 0;
      if (p[10+b]) bitv = 1 - bitv;
      r += bitv << b;
    end
    return r;
  endfunction

  task automatic load(input logic [15:0] seed);
    for (int l = 0; l < L; l++) in_data[l*W +: W] = word_of(seed, l);
  endtask

  task automatic run_vec(input logic [15:0] pat, input logic [31:0] act,
                         input logic [15:0] seed, input string tag);
    bit ok = 1;
    @(negedge clk);
    load(seed);
    pattern   = pat;
    in_active = act;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid) begin
      ok = 0;
      $display("FAIL %s R8 out_valid actual=%0b expected=1", tag, out_valid);
    end
    for (int l = 0; l < L; l++) begin
      logic [31:0] e = act[exp_src[l]] ? word_of(seed, exp_src[l]) : 32'h0;
      if (ok && out_data[l*W +: W] !== e) begin
        ok = 0;
        $display("FAIL %s pat=%h lane=%0d actual=%h expected=%h",
                 tag, pat, l, out_data[l*W +: W], e);
      end
    end
    if (!ok) bad++;
  endtask

  function automatic logic [31:0] act_of(input int i);
    case (i % 3)
      0: return 32'hFFFF_FFFF;
      1: return 32'hA5C3_0FF1;
      default: return ~(32'h1 << (i % 32));
    endcase
  endfunction

  task automatic check1(input bit cond, input string msg, input logic [31:0] act_v,
                        input logic [31:0] exp_v);
    checks++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act_v, exp_v);
    end
  endtask

  initial begin : main
    int n;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    check1(out_valid == 1'b0, "R10 out_valid at reset", 32'(out_valid), 0);
    check1(out_data == '0, "R10 out_data at reset", out_data[31:0], 0);
    check1(in_ready == 1'b1, "R10 in_ready at reset", 32'(in_ready), 1);
    rst_n = 1'b1;

    // R6: default zero pattern
    for (int l = 0; l < L; l++) exp_src[l] = 0;
    run_vec(16'h0000, 32'hFFFF_FFFF, 16'h1111, "R6 zero pattern");
    // R7: source lane 0 inactive, everything zero
    run_vec(16'h0000, 32'hFFFF_FFFE, 16'h2222, "R7 inactive source");

    // R1: all quad patterns
    for (int q = 0; q < 256; q++) begin
      p = 16'h8000 | 16'(q);
      for (int l = 0; l < L; l++) exp_src[l] = quad_src(p, l);
      run_vec(p, act_of(q), 16'(q + 16'h100), "R1 quad");
    end

    // R2: spread of bitmask patterns
    n = 0;
    for (int v = 0; v < 32768; v += 97) begin
      p = 16'(v);
      for (int l = 0; l < L; l++) exp_src[l] = mask_src(p, l);
      run_vec(p, act_of(n), 16'(v ^ 16'h3C00), "R2 bitmask");
      n++;
    end

    // R3: broadcast, R4: swap, R5: reverse
    for (int k = 1; k <= 5; k++) begin
      int sz = 1 << k;
      for (int i = 0; i < sz; i++) begin
        p = 16'((i << 5) | ((~(sz - 1)) & 31));
        for (int l = 0; l < L; l++) exp_src[l] = (l / sz) * sz + i;
        run_vec(p, act_of(i + k), 16'(sz * 64 + i), "R3 broadcast");
      end
      for (int l = 0; l < L; l++) exp_src[l] = (l / sz) * sz + (sz - 1) - (l % sz);
      run_vec(16'(((sz - 1) << 10) | 31), act_of(k), 16'(16'h7700 + k), "R5 reverse");
      run_vec(16'(((sz - 1) << 10) | 31), 32'hFFFF_FFFF, 16'(16'h7800 + k), "R5 reverse full");
    end
    for (int k = 0; k <= 4; k++) begin
      int sz = 1 << k;
      for (int l = 0; l < L; l++) exp_src[l] = ((l / sz) % 2 == 0) ? l + sz : l - sz;
      run_vec(16'((sz << 10) | 31), act_of(k), 16'(16'h6600 + k), "R4 swap");
      run_vec(16'((sz << 10) | 31), 32'hFFFF_FFFF, 16'(16'h6700 + k), "R4 swap full");
    end

    // R8 drain and R9 back-pressure
    @(negedge clk);
    check1(out_valid == 1'b0, "R8 drain", 32'(out_valid), 0);
    out_ready = 1'b0;
    for (int l = 0; l < L; l++) exp_src[l] = l;
    load(16'hAAAA);
    pattern = 16'h001F; in_active = '1; in_valid = 1'b1;
    @(negedge clk);
    check1(out_valid == 1'b1, "R8 valid under stall", 32'(out_valid), 1);
    check1(out_data[5*W +: W] == word_of(16'hAAAA, 5), "R8 first word", out_data[5*W +: W], word_of(16'hAAAA, 5));
    load(16'hBBBB);
    #0;
    check1(in_ready == 1'b0, "R9 in_ready low", 32'(in_ready), 0);
    @(negedge clk);
    check1(out_data[5*W +: W] == word_of(16'hAAAA, 5), "R9 hold", out_data[5*W +: W], word_of(16'hAAAA, 5));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check1(out_data[5*W +: W] == word_of(16'hBBBB, 5), "R9 after release", out_data[5*W +: W], word_of(16'hBBBB, 5));
    @(negedge clk);
    check1(out_valid == 1'b0, "R8 drain after release", 32'(out_valid), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule